// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block sits on the host side of an 8-bit asynchronous NOR-style flash bus. It takes one request at a time over a valid/ready handshake. Four kinds are accepted: read a byte, program a byte, erase the whole chip, or read an identification code. Each request becomes a fixed series of bus cycles, driven by a synchronous state machine. Every strobe width, setup margin and access wait is a clock-cycle count derived from the clock period parameter.

Program and erase requests end with status polling. The controller reads the flash repeatedly until the top data bit reports completion. If that takes too long, it reports a timeout. Each request gets exactly one response pulse, carrying the last byte read and an error flag.

The data bus is split into output, output-enable and input, so the pad-level tristate stays outside the block. Operation codes on `req_op` are: 0 read, 1 program, 2 chip erase, 3 identify.

Top module: `pfp_top`

## Requirements
- R1: A program request (op 1) issues four write cycles in this order: 0xAA to 0x05555, 0x55 to 0x02AAA, 0xA0 to 0x05555, then the request data to the request address.
- R2: In every write cycle, CE# is low throughout the WE# low pulse. WE# stays low for at least 200 ns and stays high for at least 200 ns between pulses. Data is stable at least 100 ns before WE# rises. The address does not change from the falling WE# edge until WE# rises at least 200 ns later.
- R3: OE# is high whenever WE# is low.
- R4: The data output enable is low whenever OE# is low. Read data is sampled only after OE# and CE# have been low for at least 70 ns.
- R5: After the program write, the target address is read repeatedly until bit 7 equals bit 7 of the programmed data. The response then carries that last read byte with the error flag clear.
- R6: A chip erase request (op 2) issues six writes: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x10@0x05555. It then polls address 0 until bit 7 reads 1.
- R7: A read request (op 0) performs one read cycle at the request address and returns that byte with the error flag clear.
- R8: An identify request (op 3) does the following, in order:
  - writes 0xAA@0x05555, 0x55@0x02AAA and 0x90@0x05555;
  - reads address 0 or 1, chosen by bit 0 of the request address;
  - writes 0xF0@0x05555.
  It returns the byte it read. Later reads see normal array contents.
- R9: A polling loop that reaches POLL_MAX reads without a match ends the request with the error flag set.
- R10: Reset leaves the block in this state:
  - `req_ready` is high;
  - CE#, OE# and WE# are high;
  - the output enable is low.

  `req_ready` is low from acceptance until the response. `rsp_valid` lasts one cycle, and `rsp_err` is only ever high together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this cycle if valid |
| req_op | input | 2 | 0 read, 1 program, 2 chip erase, 3 identify |
| req_addr | input | ADDR_W | Target address (bit 0 selects the code for identify) |
| req_wdata | input | DATA_W | Byte to program |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Last byte read during the request |
| rsp_err | output | 1 | Polling budget exhausted |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_dq_o | output | DATA_W | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_o |
| fl_dq_i | input | DATA_W | Data returned by the flash |

## Verification
Every result of this block is due on the single cycle where `rsp_valid` pulses. That cycle comes a variable number of clocks after acceptance, because polling length depends on the flash.

The bench handles request timing as follows:
- It drives requests on falling clock edges.
- It waits for the pulse on falling edges, under a per-request cycle limit.
- It compares data and error flag there.
- On the next falling edge it confirms that the pulse has gone.
- It checks `req_ready` one half-cycle after the accepting edge.

Bus timing is not tied to clock counts in the bench. A behavioural flash model measures the following in nanoseconds at each WE# edge:
- pulse width;
- high time between pulses;
- data setup;
- address hold.

The model only acts on correctly formed command sequences, so a wrong sequence shows up as wrong data.

// File: rtl/pfp_pkg.sv
`timescale 1ns/1ps
package pfp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_IDENT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_WR   = 2'd0,
    K_RD   = 2'd1,
    K_POLL = 2'd2,
    K_END  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    C_IDLE  = 2'd0,
    C_ISSUE = 2'd1,
    C_WAIT  = 2'd2,
    C_RESP  = 2'd3
  } ctl_e;

  typedef enum logic [2:0] {
    B_IDLE  = 3'd0,
    B_WSET  = 3'd1,
    B_STRB  = 3'd2,
    B_REST  = 3'd3,
    B_RSET  = 3'd4,
    B_ACC   = 3'd5,
    B_RECOV = 3'd6
  } phy_e;

  localparam int STEP_W = 3;
endpackage

// File: rtl/pfp_cmd_rom.sv
`timescale 1ns/1ps
module pfp_cmd_rom #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  pfp_pkg::op_e                 op,
  input  logic [pfp_pkg::STEP_W-1:0]   step,
  input  logic [ADDR_W-1:0]            base_addr,
  input  logic [DATA_W-1:0]            wdata,
  output pfp_pkg::kind_e               kind,
  output logic [ADDR_W-1:0]            addr,
  output logic [DATA_W-1:0]            data,
  output logic                         tgt
);
  import pfp_pkg::*;

  localparam logic [ADDR_W-1:0] UA_HI = ADDR_W'(20'h05555);
  localparam logic [ADDR_W-1:0] UA_LO = ADDR_W'(20'h02AAA);
  localparam logic [DATA_W-1:0] C_AA  = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] C_55  = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] C_PRG = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] C_ER1 = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] C_ER2 = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] C_IDN = DATA_W'(8'h90);
  localparam logic [DATA_W-1:0] C_EXT = DATA_W'(8'hF0);

  always_comb begin
    kind = K_END;
    addr = '0;
    data = '0;
    tgt  = 1'b0;
    unique case (op)
      OP_READ: begin
        if (step == 3'd0) begin
          kind = K_RD;
          addr = base_addr;
        end
      end
      OP_PROG: begin
        unique case (step)
          3'd0: begin kind = K_WR; addr = UA_HI; data = C_AA;  end
          3'd1: begin kind = K_WR; addr = UA_LO; data = C_55;  end
          3'd2: begin kind = K_WR; addr = UA_HI; data = C_PRG; end
          3'd3: begin kind = K_WR; addr = base_addr; data = wdata; end
          3'd4: begin kind = K_POLL; addr = base_addr; tgt = wdata[DATA_W-1]; end
          default: kind = K_END;
        endcase
      end
      OP_ERASE: begin
        unique case (step)
          3'd0: begin kind = K_WR; addr = UA_HI; data = C_AA;  end
          3'd1: begin kind = K_WR; addr = UA_LO; data = C_55;  end
          3'd2: begin kind = K_WR; addr = UA_HI; data = C_ER1; end
          3'd3: begin kind = K_WR; addr = UA_HI; data = C_AA;  end
          3'd4: begin kind = K_WR; addr = UA_LO; data = C_55;  end
          3'd5: begin kind = K_WR; addr = UA_HI; data = C_ER2; end
          3'd6: begin kind = K_POLL; addr = '0; tgt = 1'b1; end
          default: kind = K_END;
        endcase
      end
      OP_IDENT: begin
        unique case (step)
          3'd0: begin kind = K_WR; addr = UA_HI; data = C_AA;  end
          3'd1: begin kind = K_WR; addr = UA_LO; data = C_55;  end
          3'd2: begin kind = K_WR; addr = UA_HI; data = C_IDN; end
          3'd3: begin kind = K_RD; addr = {{(ADDR_W-1){1'b0}}, base_addr[0]}; end
          3'd4: begin kind = K_WR; addr = UA_HI; data = C_EXT; end
          default: kind = K_END;
        endcase
      end
      default: kind = K_END;
    endcase
  end
endmodule

// File: rtl/pfp_bus_phy.sv
`timescale 1ns/1ps
module pfp_bus_phy #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 10,
  parameter int WP_NS  = 200,
  parameter int WPH_NS = 200,
  parameter int ACC_NS = 70
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i
);
  import pfp_pkg::*;

  localparam int WP_CYC  = (WP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int WPH_CYC = (WPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int ACC_CYC = (ACC_NS + CLK_NS - 1) / CLK_NS + 1;
  localparam int M1      = (WP_CYC > WPH_CYC) ? WP_CYC : WPH_CYC;
  localparam int MAXC    = (M1 > ACC_CYC) ? M1 : ACC_CYC;
  localparam int CNT_W   = $clog2(MAXC + 1);

  phy_e             st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= B_IDLE;
      cnt      <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      fl_addr  <= '0;
      fl_ce_n  <= 1'b1;
      fl_oe_n  <= 1'b1;
      fl_we_n  <= 1'b1;
      fl_dq_o  <= '0;
      fl_dq_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        B_IDLE: begin
          if (go) begin
            fl_addr  <= addr;
            fl_ce_n  <= 1'b0;
            fl_oe_n  <= 1'b1;
            fl_we_n  <= 1'b1;
            fl_dq_o  <= wdata;
            fl_dq_oe <= is_wr;
            st       <= is_wr ? B_WSET : B_RSET;
          end
        end
        B_WSET: begin
          fl_we_n <= 1'b0;
          cnt     <= CNT_W'(WP_CYC - 1);
          st      <= B_STRB;
        end
        B_STRB: begin
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            cnt     <= CNT_W'(WPH_CYC - 1);
            st      <= B_REST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_REST: begin
          if (cnt == '0) begin
            fl_ce_n  <= 1'b1;
            fl_dq_oe <= 1'b0;
            done     <= 1'b1;
            st       <= B_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_RSET: begin
          fl_oe_n <= 1'b0;
          cnt     <= CNT_W'(ACC_CYC - 1);
          st      <= B_ACC;
        end
        B_ACC: begin
          if (cnt == '0) begin
            rdata   <= fl_dq_i;
            fl_oe_n <= 1'b1;
            fl_ce_n <= 1'b1;
            st      <= B_RECOV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_RECOV: begin
          done <= 1'b1;
          st   <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_oe_n);
  a_r2_ce_covers_strobe: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> !fl_ce_n);
  a_r4_released_under_oe: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> !fl_dq_oe);
  a_r2_addr_held_in_strobe: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_o)));
endmodule

// File: rtl/pfp_poll_budget.sv
`timescale 1ns/1ps
module pfp_poll_budget #(
  parameter int POLL_MAX = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic miss,
  output logic last
);
  localparam int PC_W = $clog2(POLL_MAX + 1);

  logic [PC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (miss && !last) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == PC_W'(POLL_MAX - 1));

  a_r9_budget_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt < PC_W'(POLL_MAX));
endmodule

// File: rtl/pfp_top.sv
`timescale 1ns/1ps
module pfp_top #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int WP_NS    = 200,
  parameter int WPH_NS   = 200,
  parameter int ACC_NS   = 70,
  parameter int POLL_MAX = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_i
);
  import pfp_pkg::*;

  ctl_e                st;
  op_e                 op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [STEP_W-1:0]   step;
  logic [DATA_W-1:0]   last_rd;
  logic                go;
  kind_e               s_kind;
  logic [ADDR_W-1:0]   s_addr;
  logic [DATA_W-1:0]   s_data;
  logic                s_tgt;
  logic                bus_done;
  logic [DATA_W-1:0]   bus_rd;
  logic                poll_clr;
  logic                poll_miss;
  logic                poll_last;

  pfp_cmd_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rom (
    .op(op_q), .step(step), .base_addr(addr_q), .wdata(wdata_q),
    .kind(s_kind), .addr(s_addr), .data(s_data), .tgt(s_tgt)
  );

  pfp_bus_phy #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
    .WP_NS(WP_NS), .WPH_NS(WPH_NS), .ACC_NS(ACC_NS)
  ) u_phy (
    .clk(clk), .rst(rst), .go(go), .is_wr(s_kind == K_WR),
    .addr(s_addr), .wdata(s_data), .done(bus_done), .rdata(bus_rd),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i)
  );

  assign poll_clr  = (st == C_IDLE);
  assign poll_miss = (st == C_WAIT) && bus_done && (s_kind == K_POLL) &&
                     (bus_rd[DATA_W-1] != s_tgt);

  pfp_poll_budget #(.POLL_MAX(POLL_MAX)) u_budget (
    .clk(clk), .rst(rst), .clr(poll_clr), .miss(poll_miss), .last(poll_last)
  );

  assign req_ready = (st == C_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      wdata_q   <= '0;
      step      <= '0;
      last_rd   <= '0;
      go        <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      go <= 1'b0;
      unique case (st)
        C_IDLE: begin
          if (req_valid) begin
            op_q    <= op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            step    <= '0;
            st      <= C_ISSUE;
          end
        end
        C_ISSUE: begin
          if (s_kind == K_END) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= last_rd;
            rsp_err   <= 1'b0;
            st        <= C_RESP;
          end else begin
            go <= 1'b1;
            st <= C_WAIT;
          end
        end
        C_WAIT: begin
          if (bus_done) begin
            unique case (s_kind)
              K_POLL: begin
                last_rd <= bus_rd;
                if (bus_rd[DATA_W-1] == s_tgt) begin
                  step <= step + 1'b1;
                  st   <= C_ISSUE;
                end else if (poll_last) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= bus_rd;
                  rsp_err   <= 1'b1;
                  st        <= C_RESP;
                end else begin
                  st <= C_ISSUE;
                end
              end
              K_RD: begin
                last_rd <= bus_rd;
                step    <= step + 1'b1;
                st      <= C_ISSUE;
              end
              default: begin
                step <= step + 1'b1;
                st   <= C_ISSUE;
              end
            endcase
          end
        end
        C_RESP: begin
          rsp_valid <= 1'b0;
          rsp_err   <= 1'b0;
          st        <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  a_r10_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r10_err_with_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r4_no_strobe_in_read: assert property (@(posedge clk) disable iff (rst)
    !fl_oe_n |-> fl_we_n);
endmodule

// File: tb/sim_pfp_top.sv
`timescale 1ns/1ps
module sim_pfp_top;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam real PROG_NS  = 500.0;
  localparam real ERASE_NS = 4000.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;
  logic [AW-1:0] fl_addr;
  logic          fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [DW-1:0] fl_dq_o;
  logic [DW-1:0] fl_dq_i = '0;

  int n_tests = 0, n_fail = 0;
  int m_tests = 0, m_fail = 0;
  int c_tests = 0, c_fail = 0;

  always #5 clk = ~clk;

  pfp_top #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(10), .POLL_MAX(64)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_dq_i(fl_dq_i)
  );

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [int unsigned];
  int   stage = 0;
  bit   arm_prog = 0;
  bit   id_mode = 0;
  bit   started = 0;
  real  busy_end = 0.0;
  bit   busy_erase = 0;
  logic [7:0] ld_data = '0;
  real  t_oe = 0.0, t_addr = 0.0, t_dq = 0.0, t_wfall = 0.0, t_wrise = -1.0;
  logic [AW-1:0] a_lat = '0;

  function automatic logic [7:0] arr_rd(logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hFF;
  endfunction

  function automatic logic [7:0] model_rd(logic [AW-1:0] a);
    if ($realtime < busy_end) return busy_erase ? 8'h00 : {~ld_data[7], 7'h55};
    if (id_mode) return (a == 0) ? 8'h1F : ((a == 1) ? 8'h12 : 8'h00);
    return arr_rd(a);
  endfunction

  always @(negedge fl_oe_n) t_oe = $realtime;
  always @(fl_addr) t_addr = $realtime;
  always @(fl_dq_o or fl_dq_oe) t_dq = $realtime;

  always @(posedge clk or negedge clk)
    fl_dq_i <= (!fl_ce_n && !fl_oe_n && ($realtime - t_oe >= 70.0)) ? model_rd(fl_addr) : 8'h00;

  always @(fl_we_n) begin
    if (started && fl_we_n === 1'b0) begin
      t_wfall = $realtime;
      a_lat   = fl_addr;
      m_tests++;
      if (fl_ce_n !== 1'b0 || fl_oe_n !== 1'b1) begin
        m_fail++;
        $display("FAIL R3 strobe fall with ce_n=%b oe_n=%b expected 0/1", fl_ce_n, fl_oe_n);
      end
      if (t_wrise >= 0.0 && (t_wfall - t_wrise) < 200.0) begin
        m_fail++;
        $display("FAIL R2 WE high %0t ns expected >=200", t_wfall - t_wrise);
      end
    end else if (started && fl_we_n === 1'b1) begin
      t_wrise = $realtime;
      m_tests++;
      if ((t_wrise - t_wfall) < 200.0 || !fl_dq_oe || (t_wrise - t_dq) < 100.0 ||
          t_addr > t_wfall || fl_ce_n !== 1'b0) begin
        m_fail++;
        $display("FAIL R2 pulse %0t ns setup %0t ns addr_chg_after_fall=%0d expected >=200/>=100/0",
                 t_wrise - t_wfall, t_wrise - t_dq, t_addr > t_wfall);
      end
      if ($realtime >= busy_end) model_write(a_lat, fl_dq_o);
    end
  end

  task automatic model_write(logic [AW-1:0] a, logic [7:0] d);
    logic [14:0] lo = a[14:0];
    if (arm_prog) begin
      mem[int'(a)] = arr_rd(a) & d;
      ld_data = d;
      busy_erase = 0;
      busy_end = $realtime + PROG_NS;
      arm_prog = 0;
      stage = 0;
    end else if (d == 8'hF0) begin
      id_mode = 0;
      stage = 0;
    end else begin
      case (stage)
        0: stage = (lo == 15'h5555 && d == 8'hAA) ? 1 : 0;
        1: stage = (lo == 15'h2AAA && d == 8'h55) ? 2 : 0;
        2: begin
          stage = 0;
          if (lo == 15'h5555 && d == 8'hA0) arm_prog = 1;
          else if (lo == 15'h5555 && d == 8'h90) id_mode = 1;
          else if (lo == 15'h5555 && d == 8'h80) stage = 3;
        end
        3: stage = (lo == 15'h5555 && d == 8'hAA) ? 4 : 0;
        4: stage = (lo == 15'h2AAA && d == 8'h55) ? 5 : 0;
        5: begin
          stage = 0;
          if (lo == 15'h5555 && d == 8'h10) begin
            mem.delete();
            busy_erase = 1;
            busy_end = $realtime + ERASE_NS;
          end
        end
        default: stage = 0;
      endcase
    end
  endtask

  // R4: no drive while the flash may drive; read cycles wait >= 70 ns
  always @(negedge clk) begin
    if (started) begin
      c_tests++;
      if (!fl_oe_n && fl_dq_oe) begin
        c_fail++;
        $display("FAIL R4 contention oe_n=%b dq_oe=%b expected dq_oe=0", fl_oe_n, fl_dq_oe);
      end
    end
  end

  // ---------------- bench procedures ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(logic [1:0] op, logic [AW-1:0] a, logic [7:0] d,
                        output logic [7:0] rd, output logic er);
    int wd = 0;
    rd = '0; er = 1'b0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready && wd < 5000) begin @(negedge clk); wd++; end
    @(negedge clk);
    req_valid = 0;
    check("R10 ready low while busy", {31'd0, req_ready}, 32'd0);
    wd = 0;
    while (!rsp_valid && wd < 20000) begin @(negedge clk); wd++; end
    if (!rsp_valid) begin
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog: no response actual=0 expected=1");
      return;
    end
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    check("R10 response lasts one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    logic [7:0] rd;
    logic er;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    started = 1;
    check("R10 reset ready",  {31'd0, req_ready}, 32'd1);
    check("R10 reset ce_n",   {31'd0, fl_ce_n},   32'd1);
    check("R10 reset oe_n",   {31'd0, fl_oe_n},   32'd1);
    check("R10 reset we_n",   {31'd0, fl_we_n},   32'd1);
    check("R10 reset dq_oe",  {31'd0, fl_dq_oe},  32'd0);
    check("R10 reset rsp",    {31'd0, rsp_valid}, 32'd0);

    do_req(2'd0, 19'h00000, 8'h00, rd, er);
    check("R7 read erased low", {24'd0, rd}, 32'hFF);
    check("R7 err clear", {31'd0, er}, 32'd0);
    do_req(2'd0, 19'h7FFFF, 8'h00, rd, er);
    check("R7 read erased top", {24'd0, rd}, 32'hFF);

    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a = (i == 7) ? 19'h7FFFF : AW'(i * 32'h9249 + i);
      logic [7:0] d = 8'h5A ^ 8'(i * 29);
      do_req(2'd1, a, d, rd, er);
      check("R5 program status", {24'd0, rd}, {24'd0, d});
      check("R1 program err clear", {31'd0, er}, 32'd0);
      do_req(2'd0, a, 8'h00, rd, er);
      check("R1 program readback", {24'd0, rd}, {24'd0, d});
    end

    do_req(2'd1, 19'h00100, 8'h05, rd, er);
    check("R5 prog low byte", {31'd0, er}, 32'd0);
    do_req(2'd1, 19'h00100, 8'h80, rd, er);
    check("R9 timeout flagged", {31'd0, er}, 32'd1);
    do_req(2'd0, 19'h00100, 8'h00, rd, er);
    check("R9 cell after timeout", {24'd0, rd}, 32'h00);

    do_req(2'd1, 19'h00200, 8'hF5, rd, er);
    do_req(2'd1, 19'h00200, 8'h3C, rd, er);
    check("R5 reprogram value", {24'd0, rd}, 32'h34);
    check("R5 reprogram err", {31'd0, er}, 32'd0);

    do_req(2'd3, 19'h00000, 8'h00, rd, er);
    check("R8 identify offset 0", {24'd0, rd}, 32'h1F);
    do_req(2'd3, 19'h12341, 8'h00, rd, er);
    check("R8 identify offset 1", {24'd0, rd}, 32'h12);
    do_req(2'd0, 19'h00200, 8'h00, rd, er);
    check("R8 array after exit", {24'd0, rd}, 32'h34);

    do_req(2'd2, 19'h00000, 8'h00, rd, er);
    check("R6 erase err clear", {31'd0, er}, 32'd0);
    check("R6 erase done bit", {31'd0, rd[7]}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a = (i == 7) ? 19'h7FFFF : AW'(i * 32'h9249 + i);
      do_req(2'd0, a, 8'h00, rd, er);
      check("R6 erased readback", {24'd0, rd}, 32'hFF);
    end
    do_req(2'd0, 19'h00200, 8'h00, rd, er);
    check("R6 erased partial cell", {24'd0, rd}, 32'hFF);

    repeat (5) @(negedge clk);
    check("R2 R3 strobe checks seen", {31'd0, m_tests > 0}, 32'd1);
    check("R4 contention checks seen", {31'd0, c_tests > 0}, 32'd1);
    $display("[TB] %0d tests run, %0d failed",
             n_tests + m_tests + c_tests, n_fail + m_fail + c_fail);
    $finish;
  end
endmodule